// File: doc/BRIEF.md
# Sequential Radix-2 Booth Signed Multiplier

This block multiplies two N-bit two's-complement numbers over N clock cycles using a single (N+1)-bit adder/subtractor and one (2N+1)-bit working register. The multiplier enters the low half of the register, with one guard bit of zero appended below it. The upper half starts cleared. The multiplicand is latched in a separate register. On every working cycle, the two lowest register bits select one action. The action is an addition of the multiplicand into the upper half, a subtraction of it, or nothing. The whole register then shifts right by one place, and its sign bit is replicated. Runs of ones in the multiplier are recoded this way, so signed operands need no negation before or after the loop.

A request is made by pulsing `start` with both operands present. The block reports `busy` while it iterates. It raises `done` for exactly one cycle when the 2N-bit product is ready. The product output then keeps its value until the next accepted request.

Top module: `booth_seq_mult`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is all zeros.
- R2: When `start` is high on a clock edge with `busy` low, the operands are captured. `busy` is high from the following cycle for exactly N cycles.
- R3: A low bit pair (register bit 1, guard bit 0) equal to binary 10 subtracts the multiplicand from the upper half before the shift. For example, a multiplier of all ones yields the negated multiplicand.
- R4: A low bit pair equal to binary 01 adds the multiplicand to the upper half before the shift. For example, 2 × 6 gives 12.
- R5: Bit pairs 00 and 11 perform only the shift. For example, a zero multiplier gives product 0.
- R6: The shift is arithmetic, so negative products are correctly sign-extended across all 2N bits.
- R7: With N=4, 2 × 7 gives 8'h0E and 2 × −3 gives 8'hFA.
- R8: `done` is high for exactly one cycle. That cycle is the (N+1)th cycle after the edge that accepted `start`.
- R9: The upper-half arithmetic is N+1 bits wide. Products involving the most negative multiplicand are therefore exact (N=4: −8 × −8 = 8'h40, −8 × 7 = 8'hC8).
- R10: `start` is ignored while `busy` is high. The product and the timing of `done` belong to the first request.
- R11: Between `done` and the next accepted `start`, `product` holds its value whatever the operand inputs do.
- R12: A new `start` may be accepted in the same cycle that `done` is high, and that request completes normally.
- R13: For every pair of N-bit operands, `product` equals their signed product as a 2N-bit two's-complement value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse; accepted only when idle |
| mcand | input | N | Multiplicand, two's complement |
| mplier | input | N | Multiplier, two's complement |
| busy | output | 1 | High while iterations are in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2N | Signed product |

## Verification
The completion pulse and the acceptance of a new request can fall in the same cycle. The bench provokes this by raising `start` with fresh operands as soon as it sees `done` high. It then judges that the first product was correct at that moment, that `done` drops on the next cycle and `busy` rises, and that the second product arrives exactly N+1 cycles later. A second overlap, a request arriving during iteration, is checked by confirming that both the product and the timing still belong to the first request.

// File: rtl/booth_pkg.sv
package booth_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
  } boothCtrl_t;

  // Action chosen from the low bit pair
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } boothOp_e;

endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic [1:0] lowPair,   // {register bit 1, guard bit}
  output boothOp_e   op
);

  always_comb begin
    case (lowPair)
      2'b10:   op = OP_SUB;   // R3 start of a run of ones
      2'b01:   op = OP_ADD;   // R4 end of a run of ones
      default: op = OP_NONE;  // R5 inside a run
    endcase
  end

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
#(
  parameter int N = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output boothCtrl_t strobes,
  output logic       busy,
  output logic       done
);

  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  typedef enum logic {S_IDLE, S_RUN} state_e;

  state_e        state;
  logic [CW-1:0] stepCnt;
  logic          lastStep;

  assign lastStep      = (state == S_RUN) && (stepCnt == LAST);
  assign strobes.load  = (state == S_IDLE) && start;
  assign strobes.step  = (state == S_RUN);
  assign busy          = (state == S_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            state   <= S_RUN;
            stepCnt <= '0;
          end
        end
        S_RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (lastStep) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2: an accepted start leads to busy
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R8: done is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: done only follows a busy period
  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  // R10: a start during iteration never restarts the count
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !lastStep) |=> (busy && stepCnt == $past(stepCnt) + 1'b1));

endmodule

// File: rtl/booth_dp.sv
module booth_dp
  import booth_pkg::*;
#(
  parameter int N = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  boothCtrl_t     strobes,
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  output logic [2*N-1:0] product
);

  localparam int PW = 2 * N + 1;

  logic [PW-1:0] pReg;
  logic [N-1:0]  mReg;
  logic [N:0]    hiExt;
  logic [N:0]    mExt;
  logic [N:0]    sum;
  boothOp_e      op;

  booth_recode u_recode (
    .lowPair (pReg[1:0]),
    .op      (op)
  );

  assign hiExt = {pReg[PW-1], pReg[PW-1:N+1]};
  assign mExt  = {mReg[N-1], mReg};

  always_comb begin
    case (op)
      OP_ADD:  sum = hiExt + mExt;
      OP_SUB:  sum = hiExt - mExt;
      default: sum = hiExt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pReg <= '0;
      mReg <= '0;
    end else if (strobes.load) begin
      pReg <= {{N{1'b0}}, mplier, 1'b0};
      mReg <= mcand;
    end else if (strobes.step) begin
      pReg <= {sum, pReg[N:1]};   // arithmetic shift of the widened sum
    end
  end

  assign product = pReg[PW-1:1];

  // R11: register holds when no strobe is active
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.load && !strobes.step) |=> $stable(pReg));

  // R5: a no-op pair leaves a pure shift
  a_r5_shift_only: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.step && !strobes.load && (pReg[1] == pReg[0]))
      |=> (pReg[PW-2:0] == $past(pReg[PW-1:1])));

  // R2: load places multiplier and clears upper half and guard bit
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.load |=> (pReg[N:1] == $past(mplier) && pReg[0] == 1'b0
                      && pReg[PW-1:N+1] == '0));

  // R5: the multiplicand stays put while stepping
  a_r5_mcand_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.step && !strobes.load) |=> $stable(mReg));

endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
  import booth_pkg::*;
#(
  parameter int N = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  output logic           busy,
  output logic           done,
  output logic [2*N-1:0] product
);

  boothCtrl_t strobes;

  booth_ctrl #(.N(N)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .strobes (strobes),
    .busy    (busy),
    .done    (done)
  );

  booth_dp #(.N(N)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .mcand   (mcand),
    .mplier  (mplier),
    .product (product)
  );

  // R11: product never moves between done and the next start
  a_r11_product_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));

endmodule

// File: tb/sim_booth_seq_mult.sv
module sim_booth_seq_mult;

  localparam int N = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [N-1:0]   mcand = '0;
  logic [N-1:0]   mplier = '0;
  logic           busy;
  logic           done;
  logic [2*N-1:0] product;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  booth_seq_mult #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand),
    .mplier(mplier), .busy(busy), .done(done), .product(product)
  );

  function automatic logic [2*N-1:0] refMul(input logic [N-1:0] a, input logic [N-1:0] b);
    logic signed [2*N-1:0] sa, sb, p;
    sa = {{N{a[N-1]}}, a};
    sb = {{N{b[N-1]}}, b};
    p  = sa * sb;
    return p;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Issue one request; returns cycles until done (measured at negedges)
  task automatic issue(input logic [N-1:0] a, input logic [N-1:0] b, output int lat);
    mcand = a; mplier = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 50) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic t_reset();
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 product", product, 0);
  endtask

  task automatic t_one(input string tag, input logic [N-1:0] a, input logic [N-1:0] b,
                       input logic [2*N-1:0] exp);
    int lat;
    issue(a, b, lat);
    check(tag, product, exp);
    @(negedge clk);
  endtask

  task automatic t_timing();
    int lat;
    mcand = 4'd3; mplier = 4'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", busy, 1);
    issue_wait(lat);
    check("R8 latency", lat, N + 1);
    check("R8 busy low at done", busy, 0);
    @(negedge clk);
    check("R8 done one cycle", done, 0);
  endtask

  task automatic issue_wait(output int lat);
    lat = 1;
    while (!done && lat < 50) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic t_ignore();
    int lat;
    mcand = 4'd3; mplier = 4'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    mcand = 4'd7; mplier = 4'd7; start = 1'b1;   // must be ignored
    @(negedge clk);
    start = 1'b0;
    lat = 3;
    while (!done && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    check("R10 latency kept", lat, N + 1);
    check("R10 first product", product, 8'h06);
    @(negedge clk);
    check("R10 no second run", busy, 0);
  endtask

  task automatic t_hold();
    int lat;
    logic [2*N-1:0] snap;
    issue(4'hD, 4'h3, lat);   // -3 * 3 = -9
    snap = product;
    check("R11 value", snap, 8'hF7);
    for (int i = 0; i < 6; i++) begin
      mcand = 4'(i); mplier = 4'(i + 5);
      @(negedge clk);
    end
    check("R11 held", product, snap);
  endtask

  task automatic t_backtoback();
    int lat;
    issue(4'd5, 4'd5, lat);
    check("R12 first product", product, 8'h19);
    mcand = 4'hA; mplier = 4'd3; start = 1'b1;   // -6 * 3, while done high
    @(negedge clk);
    start = 1'b0;
    check("R12 done dropped", done, 0);
    check("R12 accepted", busy, 1);
    issue_wait(lat);
    check("R12 latency", lat, N + 1);
    check("R12 second product", product, 8'hEE);
    @(negedge clk);
  endtask

  task automatic t_exhaustive();
    int lat;
    int bad;
    bad = 0;
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        issue(4'(a), 4'(b), lat);
        if (product !== refMul(4'(a), 4'(b)) || lat != N + 1) begin
          bad++;
          $display("FAIL R13 a=%0h b=%0h actual=%0h expected=%0h", a, b, product,
                   refMul(4'(a), 4'(b)));
        end
        @(negedge clk);
      end
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_one("R7 2x7", 4'd2, 4'd7, 8'h0E);
        t_one("R7 2x-3", 4'd2, 4'hD, 8'hFA);
        t_one("R3 5x-1", 4'd5, 4'hF, 8'hFB);
        t_one("R4 2x6", 4'd2, 4'd6, 8'h0C);
        t_one("R5 7x0", 4'd7, 4'd0, 8'h00);
        t_one("R6 -7x5", 4'h9, 4'd5, 8'hDD);
        t_one("R9 -8x-8", 4'h8, 4'h8, 8'h40);
        t_one("R9 -8x7", 4'h8, 4'd7, 8'hC8);
        t_timing();
        t_ignore();
        t_hold();
        t_backtoback();
        t_exhaustive();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule